// File: doc/BRIEF.md
# Serial ADC Conversion Frame Controller

This block is the host side of a link to a 12-bit serial analog-to-digital converter. It generates the converter's serial clock by dividing the system clock. It drives an active-low convert strobe that also marks the start of a frame. It shifts in the converter's data line and presents each finished sample on a parallel bus, with a one-cycle valid pulse.

A frame is one sync slot followed by 16 data slots. A slot is one serial-clock period. The 16-bit word carries three leading zeros, then the 12 sample bits with the most significant bit first, then one trailing zero. A pulse on `start_i` runs one frame. Holding `continuous_i` high chains frames back to back: the next frame's strobe overlaps the last slot of the current word, so no idle slots appear between frames. A power-down request runs a shortened frame of only 8 data slots. After it the strobe stays high, which keeps the converter asleep until the next conversion.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is applied, `adc_conv_n_o` is 1, `adc_sclk_o` equals `cpol_i`, `sample_valid_o` is 0, and `sample_o` and `format_error_o` are 0.
- R2: The serial-clock period is 2*max(1,`half_period_i`) system clocks. `half_period_i` is sampled in the cycle a frame is launched and holds for the whole frame. A value of 0 acts as 1.
- R3: When idle, `adc_sclk_o` equals `cpol_i`. During a frame, each slot is low for its first half and high for its second half, for either polarity. The data line is sampled at the low-to-high transition.
- R4: In idle, a `start_i` pulse drives `adc_conv_n_o` low for exactly the sync slot. Sixteen data slots follow, then idle. A `start_i` that arrives during a frame is ignored and is not queued.
- R5: `sample_valid_o` is high for one cycle, the cycle after the sampling edge of data slot 15. `sample_o` then holds bits 3 to 14 of the word (slot 3 is the MSB). It stays unchanged until the next valid.
- R6: `format_error_o` is updated together with each valid. It is 1 when any of data slots 0, 1, 2 or 15 was captured as 1, and 0 otherwise.
- R7: The data line is ignored outside the 16 data slots. The bench holds the line at 1 in idle and during the sync slot, and the result still shows zero leading bits.
- R8: If `continuous_i` is high at the start of data slot 15, `adc_conv_n_o` is low for that slot and the next frame's data slot 0 follows at once. Valids are then 32*H system clocks apart.
- R9: If `continuous_i` is low at the start of data slot 15, the current frame completes with its valid and the controller goes idle.
- R10: A `powerdown_i` request taken in idle runs a sync slot plus 8 data slots. It gives no valid and leaves `sample_o` unchanged. `adc_conv_n_o` stays high afterwards.
- R11: If `start_i` and `powerdown_i` arrive together in idle, a full conversion runs. A `powerdown_i` request that arrives during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpol_i | input | 1 | Idle level of the serial clock (0 or 1) |
| half_period_i | input | HALF_W | Half of the serial-clock period, in system clocks |
| start_i | input | 1 | Request one conversion |
| continuous_i | input | 1 | Keep conversions running back to back |
| powerdown_i | input | 1 | Request a shortened power-down frame |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_conv_n_o | output | 1 | Convert strobe and frame sync, active low |
| sample_o | output | DATA_W | Last captured sample |
| sample_valid_o | output | 1 | One-cycle pulse when a sample completes |
| format_error_o | output | 1 | Padding bits of the last frame were not zero |

## Verification
The bench builds the controller with its default parameters: a 12-bit sample, a 16-slot word, an 8-slot power-down frame and an 8-bit divider field. It then steps the run-time half-period through 0, 1, 2 and 3. This covers the clamp of zero, the shortest two-cycle serial clock, and odd multi-cycle halves, in both clock polarities. With these short periods, chained continuous frames, the convert-strobe overlap on the last slot and the 8-slot power-down frame all fit within a short run. Each of them is followed cycle by cycle by a timing model.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  // Sequencer phases: waiting, frame-sync slot, data slots
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } fsm_state_e;

endpackage

// File: rtl/sclk_timer.sv
module sclk_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              launch_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              rise_o,
  output logic              slot_end_o,
  output logic              phase_o
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] hc_q, hc_d;
  logic              ph_q, ph_d;
  logic              tick;

  assign tick = run_i && (hc_q == (half_i - ONE));

  always_comb begin
    hc_d = hc_q;
    ph_d = ph_q;
    if (launch_i) begin
      hc_d = '0;
      ph_d = 1'b0;
    end else if (run_i) begin
      if (tick) begin
        hc_d = '0;
        ph_d = ~ph_q;
      end else begin
        hc_d = hc_q + ONE;
      end
    end else begin
      hc_d = '0;
      ph_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q <= '0;
      ph_q <= 1'b0;
    end else begin
      hc_q <= hc_d;
      ph_q <= ph_d;
    end
  end

  assign rise_o     = tick && !ph_q;
  assign slot_end_o = tick && ph_q;
  assign phase_o    = ph_q;

  // The half-period count never passes the configured half length
  assert_half_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_q < half_i)
    else $error("half counter out of range");

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import adc_frame_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int PD_W    = 8,
  parameter int HALF_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              pd_req_i,
  input  logic [HALF_W-1:0] half_cfg_i,
  input  logic              rise_i,
  input  logic              slot_end_i,
  output logic              launch_o,
  output logic              run_o,
  output logic [HALF_W-1:0] half_o,
  output logic              conv_n_o,
  output logic              cap_en_o,
  output logic              cap_last_o,
  output logic              pd_active_o
);

  localparam logic [CNT_W-1:0]  LAST_N   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0]  LAST_PD  = CNT_W'(PD_W - 1);
  localparam logic [CNT_W-1:0]  PRE_LAST = CNT_W'(FRAME_W - 2);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [HALF_W-1:0] HALF_MIN = HALF_W'(1);

  fsm_state_e        st_q, st_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              conv_q, conv_d;
  logic              pd_q, pd_d;
  logic              cont_q, cont_d;
  logic [HALF_W-1:0] hp_q, hp_d;
  logic              go, launch;
  logic [CNT_W-1:0]  last_idx;
  logic [HALF_W-1:0] half_clamped;

  assign go           = start_i || cont_i;
  assign last_idx     = pd_q ? LAST_PD : LAST_N;
  assign half_clamped = (half_cfg_i == '0) ? HALF_MIN : half_cfg_i;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    conv_d = conv_q;
    pd_d   = pd_q;
    cont_d = cont_q;
    hp_d   = hp_q;
    launch = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go || pd_req_i) begin
          launch = 1'b1;
          st_d   = ST_SYNC;
          pd_d   = !go;
          conv_d = 1'b0;
          cont_d = 1'b0;
          bit_d  = '0;
          hp_d   = half_clamped;
        end
      end
      ST_SYNC: begin
        if (slot_end_i) begin
          st_d   = ST_DATA;
          bit_d  = '0;
          conv_d = 1'b1;
        end
      end
      ST_DATA: begin
        if (slot_end_i) begin
          if (bit_q == last_idx) begin
            conv_d = 1'b1;
            bit_d  = '0;
            cont_d = 1'b0;
            if (!(cont_q && !pd_q)) begin
              st_d = ST_IDLE;
            end
          end else begin
            bit_d = bit_q + CNT_ONE;
            if (!pd_q && (bit_q == PRE_LAST)) begin
              // next slot is the last one: strobe it when chaining
              conv_d = !cont_i;
              cont_d = cont_i;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      conv_q <= 1'b1;
      pd_q   <= 1'b0;
      cont_q <= 1'b0;
      hp_q   <= HALF_MIN;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      conv_q <= conv_d;
      pd_q   <= pd_d;
      cont_q <= cont_d;
      hp_q   <= hp_d;
    end
  end

  assign launch_o    = launch;
  assign run_o       = (st_q != ST_IDLE);
  assign half_o      = hp_q;
  assign conv_n_o    = conv_q;
  assign cap_en_o    = (st_q == ST_DATA) && rise_i && !pd_q;
  assign cap_last_o  = (bit_q == LAST_N);
  assign pd_active_o = pd_q && (st_q != ST_IDLE);

  // Strobe is low only while a frame is in progress
  assert_conv_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_q |-> (st_q != ST_IDLE))
    else $error("strobe low while idle");

  // The sync slot is exactly one serial period, then the strobe releases
  assert_sync_one_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SYNC && slot_end_i) |=> (st_q == ST_DATA && conv_q))
    else $error("sync slot did not hand over to data");

  // A power-down frame never passes its shortened slot count
  assert_pd_short_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && st_q == ST_DATA) |-> (bit_q <= LAST_PD))
    else $error("power-down frame overran");

endmodule

// File: rtl/sample_shifter.sv
module sample_shifter #(
  parameter int FRAME_W = 16,
  parameter int LEAD_W  = 3,
  parameter int DATA_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              cap_last_i,
  input  logic              sdin_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);

  localparam int TRAIL_W = FRAME_W - LEAD_W - DATA_W;
  localparam int SH_W    = FRAME_W - 1;

  logic [SH_W-1:0]    sh_q, sh_d;
  logic [FRAME_W-1:0] word;
  logic               valid_q, valid_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               ferr_q, ferr_d;
  logic               lead_bad, trail_bad;

  assign word     = {sh_q, sdin_i};
  assign lead_bad = |word[FRAME_W-1 -: LEAD_W];

  generate
    if (TRAIL_W > 0) begin : g_trail
      assign trail_bad = |word[TRAIL_W-1:0];
    end else begin : g_no_trail
      assign trail_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    sh_d    = sh_q;
    valid_d = 1'b0;
    data_d  = data_q;
    ferr_d  = ferr_q;
    if (cap_en_i) begin
      sh_d = word[SH_W-1:0];
      if (cap_last_i) begin
        valid_d = 1'b1;
        data_d  = word[TRAIL_W +: DATA_W];
        ferr_d  = lead_bad || trail_bad;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      ferr_q  <= ferr_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign ferr_o  = ferr_q;

  // A valid pulse lasts a single cycle
  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q)
    else $error("valid held longer than one cycle");

  // The result only moves together with a valid pulse
  assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(data_q) && $stable(ferr_q)))
    else $error("result changed without valid");

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DATA_W  = 12,
  parameter int LEAD_W  = 3,
  parameter int FRAME_W = 16,
  parameter int PD_W    = 8,
  parameter int HALF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic [HALF_W-1:0] half_period_i,
  input  logic              start_i,
  input  logic              continuous_i,
  input  logic              powerdown_i,
  input  logic              adc_sdo_i,
  output logic              adc_sclk_o,
  output logic              adc_conv_n_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic              format_error_o
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              launch, run, rise, slot_end, phase;
  logic              cap_en, cap_last, pd_active;
  logic [HALF_W-1:0] half_lat;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sclk_timer #(
    .HALF_W (HALF_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .run_i      (run),
    .launch_i   (launch),
    .half_i     (half_lat),
    .rise_o     (rise),
    .slot_end_o (slot_end),
    .phase_o    (phase)
  );

  frame_seq #(
    .FRAME_W (FRAME_W),
    .PD_W    (PD_W),
    .HALF_W  (HALF_W),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .start_i     (start_i),
    .cont_i      (continuous_i),
    .pd_req_i    (powerdown_i),
    .half_cfg_i  (half_period_i),
    .rise_i      (rise),
    .slot_end_i  (slot_end),
    .launch_o    (launch),
    .run_o       (run),
    .half_o      (half_lat),
    .conv_n_o    (adc_conv_n_o),
    .cap_en_o    (cap_en),
    .cap_last_o  (cap_last),
    .pd_active_o (pd_active)
  );

  sample_shifter #(
    .FRAME_W (FRAME_W),
    .LEAD_W  (LEAD_W),
    .DATA_W  (DATA_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .cap_en_i   (cap_en),
    .cap_last_i (cap_last),
    .sdin_i     (adc_sdo_i),
    .valid_o    (sample_valid_o),
    .data_o     (sample_o),
    .ferr_o     (format_error_o)
  );

  // Same active waveform in both settings; only the idle level follows cpol
  assign adc_sclk_o = run ? phase : cpol_i;

  // A shortened frame never yields a sample
  assert_no_valid_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    pd_active |-> !sample_valid_o)
    else $error("valid during power-down frame");

endmodule

// File: tb/adc_frame_ctrl_test.sv
module adc_frame_ctrl_test;

  localparam int FW  = 16;
  localparam int PDL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cpol = 1'b0;
  logic [7:0]  hp = 8'd1;
  logic        start = 1'b0;
  logic        cont = 1'b0;
  logic        pdreq = 1'b0;
  logic        sdin = 1'b1;
  logic        sclk, conv_n, valid, ferr;
  logic [11:0] data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_frame_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cpol_i         (cpol),
    .half_period_i  (hp),
    .start_i        (start),
    .continuous_i   (cont),
    .powerdown_i    (pdreq),
    .adc_sdo_i      (sdin),
    .adc_sclk_o     (sclk),
    .adc_conv_n_o   (conv_n),
    .sample_o       (data),
    .sample_valid_o (valid),
    .format_error_o (ferr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- timing model: time since launch drives everything
  bit          m_busy, m_pd, m_cont, m_valid, m_ferr;
  int          m_t, m_H, m_word;
  logic [11:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pd = 0; m_cont = 0; m_valid = 0; m_ferr = 0;
      m_t = 0; m_H = 1; m_word = 0; m_data = '0;
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (start || cont || pdreq) begin
          m_busy = 1; m_pd = !(start || cont); m_t = 0; m_cont = 0;
          m_H = (hp == 0) ? 1 : int'(hp);
        end
      end else begin
        m_t++;
        if (m_t == 2 * m_H * (m_pd ? PDL + 1 : FW + 1)) begin
          if (!m_pd && m_cont) begin
            m_t = 2 * m_H; m_cont = 0;
          end else begin
            m_busy = 0;
          end
        end
        if (m_busy && !m_pd) begin
          if (m_t == 2 * m_H * FW) m_cont = cont;
          if (m_t >= 2 * m_H && (m_t % (2 * m_H)) == m_H) begin
            m_word = (m_word << 1) | int'(sdin);
            if (m_t / (2 * m_H) - 1 == FW - 1) begin
              m_valid = 1;
              m_data  = 12'((m_word >> 1) & 12'hFFF);
              m_ferr  = (((m_word >> 13) & 7) != 0) || ((m_word & 1) != 0);
            end
          end
        end
      end
    end
  end

  // ---------------- converter model, acts between clock edges
  logic [11:0] sq[$];
  bit          bad_next = 0;
  bit          prev_sclk, armed, active, cur_bad;
  int          pos, rises;
  logic [11:0] cur;

  function automatic logic bitval(int p);
    if (p < 3)  return (cur_bad && p == 1);
    if (p < 15) return cur[14 - p];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = sclk; armed = 0; active = 0; sdin = 1'b1; rises = 0; pos = 0;
    end else begin
      if (sclk && !prev_sclk) begin
        if (active) rises++;
        if (!conv_n) begin armed = 1; rises = 0; end
      end else if (!sclk && prev_sclk) begin
        if (armed) begin
          armed = 0; active = 1; pos = 0;
          cur = (sq.size() > 0) ? sq.pop_front() : 12'h000;
          cur_bad = bad_next; bad_next = 0;
        end else if (active) begin
          pos++;
        end
        if (active) begin
          if (pos < 16) sdin = bitval(pos);
          else begin active = 0; sdin = 1'b1; end
        end
      end
      prev_sclk = sclk;
    end
  end

  // ---------------- per-cycle comparison, watchdog and monitors
  int cyc = 0, vcount = 0, last_v = 0, last_gap = 0, hi_cnt = 0;

  always @(posedge clk) begin
    #3;
    cyc++;
    if (rst_n && !done) begin
      chk(sclk == (m_busy ? (((m_t / m_H) % 2) == 1) : cpol), "R3", "sclk", sclk, 0);
      chk(conv_n == !(m_busy && (m_t < 2 * m_H ||
          (!m_pd && m_t >= 2 * m_H * FW && m_cont))), "R4", "conv_n", conv_n, 0);
      chk(valid == m_valid, "R5", "valid", valid, m_valid);
      chk(data == m_data, "R5", "sample", data, m_data);
      chk(ferr == m_ferr, "R6", "format_error", ferr, m_ferr);
      if (sclk) hi_cnt++;
      if (valid) begin
        vcount++; last_gap = cyc - last_v; last_v = cyc;
      end
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    tick(3);
  endtask

  int vb, rb;
  logic [11:0] dkeep;

  initial begin
    #1 rst_n = 1'b0;
    tick(3);
    // R1: reset state
    chk(conv_n == 1'b1, "R1", "conv_n", conv_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(valid == 1'b0, "R1", "valid", valid, 0);
    chk(data == 12'h000, "R1", "sample", data, 0);
    chk(ferr == 1'b0, "R1", "format_error", ferr, 0);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    cpol = 1'b1;
    #1 chk(sclk == 1'b1, "R3", "idle sclk with cpol=1", sclk, 1);

    // R5: single conversion, polarity 1, shortest divider
    hp = 8'd1;
    sq.push_back(12'hA5C);
    pulse_start();
    wait_idle();
    chk(vcount == 1, "R4", "one valid per start", vcount, 1);
    chk(data == 12'hA5C, "R5", "sample value", data, 12'hA5C);
    chk(ferr == 1'b0, "R6", "clean frame", ferr, 0);

    // R2: divider 3, polarity 0, second start and power-down mid-frame ignored
    cpol = 1'b0; hp = 8'd3;
    sq.push_back(12'h123);
    tick(1);
    hi_cnt = 0;
    pulse_start();
    tick(20);
    @(negedge clk) begin start = 1'b1; pdreq = 1'b1; end
    @(negedge clk) begin start = 1'b0; pdreq = 1'b0; end
    wait_idle();
    chk(hi_cnt == 17 * 3, "R2", "high cycles in frame", hi_cnt, 51);
    chk(vcount == 2, "R11", "mid-frame requests ignored", vcount, 2);
    chk(data == 12'h123, "R7", "leading bits with line high outside data", data, 12'h123);

    // R6: corrupted padding then clean frame
    cpol = 1'b1; hp = 8'd2;
    bad_next = 1;
    sq.push_back(12'hFFF);
    pulse_start();
    wait_idle();
    chk(ferr == 1'b1, "R6", "bad lead bit flagged", ferr, 1);
    chk(data == 12'hFFF, "R6", "sample with bad lead", data, 12'hFFF);
    sq.push_back(12'h000);
    pulse_start();
    wait_idle();
    chk(ferr == 1'b0, "R6", "flag cleared on clean frame", ferr, 0);
    chk(data == 12'h000, "R7", "zero sample, line high in sync slot", data, 0);

    // R8/R9: continuous frames then stop
    hp = 8'd2;
    sq.push_back(12'h111); sq.push_back(12'h222); sq.push_back(12'h333);
    vb = vcount;
    @(negedge clk) cont = 1'b1;
    while (vcount < vb + 2) @(negedge clk);
    cont = 1'b0;
    chk(last_gap == 32 * 2, "R8", "valid spacing", last_gap, 64);
    wait_idle();
    chk(vcount == vb + 3, "R9", "frame in progress completes", vcount, vb + 3);
    chk(data == 12'h333, "R8", "third chained sample", data, 12'h333);
    chk(last_gap == 32 * 2, "R8", "back-to-back spacing", last_gap, 64);
    sq.delete();

    // R10: power-down frame with clamped divider
    cpol = 1'b0; hp = 8'd0;
    vb = vcount; dkeep = data;
    @(negedge clk) pdreq = 1'b1;
    @(negedge clk) pdreq = 1'b0;
    wait_idle();
    rb = rises;
    chk(rb == 8, "R10", "clocks in power-down frame", rb, 8);
    chk(vcount == vb, "R10", "no valid", vcount, vb);
    chk(data == dkeep, "R10", "sample kept", data, dkeep);
    tick(10);
    chk(conv_n == 1'b1, "R10", "strobe held high", conv_n, 1);

    // R11: start wins over power-down
    hp = 8'd1;
    sq.push_back(12'h5A5);
    vb = vcount;
    @(negedge clk) begin start = 1'b1; pdreq = 1'b1; end
    @(negedge clk) begin start = 1'b0; pdreq = 1'b0; end
    wait_idle();
    chk(vcount == vb + 1, "R11", "full frame ran", vcount, vb + 1);
    chk(data == 12'h5A5, "R11", "sample", data, 12'h5A5);
    rb = rises;
    chk(rb == 16, "R11", "sixteen data clocks", rb, 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule